// File: doc/BRIEF.md
# Periodic Rate Tick Channel

This block is a single counting channel of a programmable interval timer, fixed to the periodic rate-generator behaviour with binary counting. Software selects the channel with a control byte and then supplies a 16-bit divisor as two data bytes, low byte first. Once both bytes are in, the channel counts input clock enables and produces a tick output. The output idles high and drops for one enable period once per divisor, so it can feed an interrupt request line.

For example, with a 1193182 Hz timebase and a desired 100 Hz tick, the divisor is 1193182 / 100 rounded to the nearest integer, which is 11932. Only the control bytes that address this channel with the supported settings take effect. All other control bytes leave the channel exactly as it was.

Top module: `rate_tick_channel`

## Requirements
- R1: While and after reset, `tick_o` is 1, no count is running and no control byte is considered received.
- R2: A control byte is accepted only when all of the following hold: bits [7:6] equal the parameter `CHAN_ID`, bits [5:4] are 2'b11 (low byte then high byte), bits [2:1] are 2'b10 (rate mode; bit 3 is don't-care) and bit 0 is 0 (binary). With `CHAN_ID` = 0, the byte 0x34 is accepted.
- R3: Every other control byte is ignored. This covers a different channel as well as an unsupported access, mode or BCD setting. The running count, the tick and the byte order are left untouched.
- R4: After an accepted control byte, the first data write is the divisor low byte and the next one is the high byte. The two writes then alternate. Data writes made before any control byte has been accepted are ignored.
- R5: Counting starts on the first cycle with `cnt_en` = 1 strictly after the cycle of the high-byte write. An accepted control byte stops the count and forces `tick_o` to 1 on the next edge. The count stays stopped until a new low/high pair is written.
- R6: With divisor N, the first `cnt_en` after the load sets the count to N. The output `tick_o` is 0 after the (N-1)th later enable and returns to 1 on the next one, at which point the count reloads N. The output is therefore low for one enable period in every N.
- R7: A divisor of 0 is treated as 65536.
- R8: A divisor pair written while the channel is counting does not disturb the current period. It takes effect at the next reload.
- R9: `tick_o` changes only on an edge where `cnt_en` is 1 or a control byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_ctrl | input | 1 | 1 selects the control port, 0 selects the data port |
| wr_data | input | 8 | Write byte |
| cnt_en | input | 1 | Input clock enable that advances the count |
| tick_o | output | 1 | Registered rate output, low for one enable period per divisor |

## Verification
The hardest situation to reach is a divisor pair that lands while a period is in progress. The pending value must then wait for a reload, and a reload may even coincide with the high-byte write or with the very first enable after a load. The random stimulus keeps divisors small and issues data writes at random moments between sparse enables, so these coincidences occur many times. Directed sequences cover the 65536 case, writes before any control byte, and ignored control bytes issued in the middle of a period.

// File: rtl/rate_tick_pkg.sv
package rate_tick_pkg;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] access;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_byte_t;

  localparam int unsigned BYTE_W = 8;
  localparam logic [1:0] ACCESS_LO_HI = 2'b11;
  localparam logic [1:0] MODE_RATE    = 2'b10;

endpackage

// File: rtl/rate_tick_decode.sv
module rate_tick_decode
  import rate_tick_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_byte,
  output logic              accept
);

  ctrl_byte_t cw;

  always_comb begin
    cw     = ctrl_byte_t'(ctrl_byte);
    accept = ctrl_we
          && (cw.chan == CHAN_ID)
          && (cw.access == ACCESS_LO_HI)
          && (cw.mode[1:0] == MODE_RATE)
          && !cw.bcd;
  end

endmodule

// File: rtl/rate_tick_loader.sv
module rate_tick_loader
  import rate_tick_pkg::*;
#(
  parameter int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] data_byte,
  output logic              div_valid,
  output logic [DIV_W-1:0]  div_val
);

  logic              prog_q;
  logic              hi_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= '0;
    end else if (arm) begin
      prog_q <= 1'b1;
      hi_q   <= 1'b0;
    end else if (data_we && prog_q) begin
      if (!hi_q) lo_q <= data_byte;
      hi_q <= !hi_q;
    end
  end

  assign div_valid = data_we && prog_q && hi_q && !arm;
  assign div_val   = DIV_W'({data_byte, lo_q});

endmodule

// File: rtl/rate_tick_counter.sv
module rate_tick_counter #(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop,
  input  logic             cnt_en,
  input  logic             div_valid,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << DIV_W;

  logic             run_q, start_q, upd_q, tick_q;
  logic [CNT_W-1:0] cnt_q, reload_q, pend_q;
  logic [CNT_W-1:0] nxt, widened;
  logic             going;

  always_comb begin
    widened = (div_val == '0) ? FULL : {1'b0, div_val};
    going   = run_q || (cnt_en && start_q);
    if (cnt_q == ONE) nxt = upd_q ? pend_q : reload_q;
    else              nxt = cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      start_q  <= 1'b0;
      upd_q    <= 1'b0;
      tick_q   <= 1'b1;
      cnt_q    <= '0;
      reload_q <= ONE;
      pend_q   <= ONE;
    end else if (stop) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      upd_q   <= 1'b0;
      tick_q  <= 1'b1;
    end else begin
      if (cnt_en && run_q) begin
        cnt_q  <= nxt;
        tick_q <= (nxt != ONE);
        if (cnt_q == ONE && upd_q) begin
          reload_q <= pend_q;
          upd_q    <= 1'b0;
        end
      end else if (cnt_en && start_q) begin
        run_q   <= 1'b1;
        start_q <= 1'b0;
        cnt_q   <= reload_q;
        tick_q  <= (reload_q != ONE);
      end
      if (div_valid) begin
        if (going) begin
          pend_q <= widened;
          upd_q  <= 1'b1;
        end else begin
          reload_q <= widened;
          start_q  <= 1'b1;
        end
      end
    end
  end

  assign tick_o   = tick_q;
  assign run_o    = run_q;
  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;

endmodule

// File: rtl/rate_tick_channel.sv
module rate_tick_channel
  import rate_tick_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0,
  parameter int unsigned DIV_BYTES = 2,
  localparam int unsigned DIV_W = DIV_BYTES * BYTE_W,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cnt_en,
  output logic              tick_o
);

  logic             cw_accept;
  logic             div_valid;
  logic [DIV_W-1:0] div_val;
  logic             run;
  logic [CNT_W-1:0] cnt, reload;

  rate_tick_decode #(.CHAN_ID(CHAN_ID)) u_dec (
    .ctrl_we   (wr_en && wr_ctrl),
    .ctrl_byte (wr_data),
    .accept    (cw_accept)
  );

  rate_tick_loader #(.DIV_W(DIV_W)) u_load (
    .clk       (clk),
    .rst       (rst),
    .arm       (cw_accept),
    .data_we   (wr_en && !wr_ctrl),
    .data_byte (wr_data),
    .div_valid (div_valid),
    .div_val   (div_val)
  );

  rate_tick_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .stop      (cw_accept),
    .cnt_en    (cnt_en),
    .div_valid (div_valid),
    .div_val   (div_val),
    .tick_o    (tick_o),
    .run_o     (run),
    .cnt_o     (cnt),
    .reload_o  (reload)
  );

endmodule

// File: rtl/rate_tick_channel_chk.sv
module rate_tick_channel_chk #(
  parameter int unsigned CNT_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             cw_accept,
  input logic             tick_o,
  input logic             run,
  input logic [CNT_W-1:0] cnt
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !run |-> tick_o);

  p_stop_on_ctrl_r5: assert property (@(posedge clk) disable iff (rst)
    cw_accept |=> (tick_o && !run));

  p_start_on_enable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(cnt_en));

  p_low_at_one_r6: assert property (@(posedge clk) disable iff (rst)
    run |-> (tick_o == (cnt != CNT_W'(1))));

  p_count_range_r7: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0 && cnt <= (CNT_W'(1) << (CNT_W - 1))));

  p_tick_moves_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(tick_o) |-> ($past(cnt_en) || $past(cw_accept)));

endmodule

bind rate_tick_channel rate_tick_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .cw_accept (cw_accept),
  .tick_o    (tick_o),
  .run       (run),
  .cnt       (cnt)
);

// File: tb/rate_tick_channel_tb_top.sv
module rate_tick_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cnt_en = 1'b0;
  logic       tick_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  rate_tick_channel dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
    .wr_data(wr_data), .cnt_en(cnt_en), .tick_o(tick_o)
  );

  // Reference model built from the requirements
  bit m_prog, m_hi, m_run, m_pend, m_upd;
  int m_div, m_next, m_phase;
  logic [7:0] m_lo;

  function automatic bit cw_ok(input logic [7:0] b);
    return (b[7:6] == 2'd0) && (b[5:4] == 2'b11) && (b[2:1] == 2'b10) && !b[0];
  endfunction

  function automatic int div_of(input logic [7:0] lo, input logic [7:0] hi);
    int v = {hi, lo};
    return (v == 0) ? 65536 : v;
  endfunction

  function automatic bit exp_tick();
    return !(m_run && (m_phase == m_div - 1));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prog = 0; m_hi = 0; m_run = 0; m_pend = 0; m_upd = 0;
      m_div = 1; m_next = 1; m_phase = 0; m_lo = 0;
    end else begin
      if (cnt_en) begin
        if (m_run) begin
          m_phase++;
          if (m_phase == m_div) begin
            m_phase = 0;
            if (m_upd) begin m_div = m_next; m_upd = 0; end
          end
        end else if (m_pend) begin
          m_run = 1; m_pend = 0; m_phase = 0;
        end
      end
      if (wr_en && wr_ctrl) begin
        if (cw_ok(wr_data)) begin
          m_prog = 1; m_hi = 0; m_run = 0; m_pend = 0; m_upd = 0;
        end
      end else if (wr_en && m_prog) begin
        if (!m_hi) begin
          m_lo = wr_data; m_hi = 1;
        end else begin
          m_hi = 0;
          if (m_run) begin m_next = div_of(m_lo, wr_data); m_upd = 1; end
          else begin m_div = div_of(m_lo, wr_data); m_pend = 1; end
        end
      end
    end
  end

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tick_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input bit ctl, input logic [7:0] d, input bit en);
    wr_en = we; wr_ctrl = ctl; wr_data = d; cnt_en = en;
    @(negedge clk);
    check(tick_o, exp_tick(), cur_req);
    wr_en = 0; wr_ctrl = 0; cnt_en = 0;
  endtask

  task automatic idle(input int n, input bit en);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, en);
  endtask

  task automatic load(input logic [7:0] lo, input logic [7:0] hi);
    cyc(1, 0, lo, 0);
    cyc(1, 0, hi, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tick_o, 1'b1, "R1");
    end
    rst = 0;
    idle(3, 1);

    // R4: data before any control byte is ignored
    cur_req = "R4";
    load(8'h03, 8'h00);
    idle(10, 1);

    // R2/R6: 0x34 with divisor 5, continuous enables
    cur_req = "R6";
    cyc(1, 1, 8'h34, 1);
    load(8'h05, 8'h00);
    idle(23, 1);

    // R3: ignored control bytes mid-period
    cur_req = "R3";
    cyc(1, 1, 8'h74, 1);
    idle(2, 1);
    cyc(1, 1, 8'h32, 1);
    cyc(1, 1, 8'h35, 1);
    cyc(1, 1, 8'h24, 1);
    idle(12, 1);

    // R8: new pair while counting, sparse enables
    cur_req = "R8";
    idle(1, 1);
    load(8'h07, 8'h00);
    for (int i = 0; i < 40; i++) cyc(0, 0, 8'h00, i[0]);

    // R5: stop and restart, alternate mode-bit spelling 0x3C
    cur_req = "R5";
    cyc(1, 1, 8'h3C, 1);
    idle(6, 1);
    cyc(1, 0, 8'h03, 1);
    cyc(1, 0, 8'h00, 1);
    idle(10, 1);

    // R7: divisor 0 counts 65536
    cur_req = "R7";
    cyc(1, 1, 8'h34, 0);
    load(8'h00, 8'h00);
    begin
      int first_low = -1;
      for (int i = 1; i <= 65540; i++) begin
        cyc(0, 0, 8'h00, 1);
        if (!tick_o && first_low < 0) first_low = i;
      end
      checks++;
      if (first_low != 65536) begin
        fails++;
        $display("FAIL R7: first low at enable %0d expected 65536", first_low);
      end
    end

    // R9 and mixed: constrained random
    cur_req = "R9";
    cyc(1, 1, 8'h34, 0);
    load(8'h04, 8'h00);
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom % 100;
      if (r < 2) cyc(1, 1, 8'($urandom), $urandom % 2);
      else if (r < 4) cyc(1, 1, ($urandom % 2) ? 8'h34 : 8'h3C, $urandom % 2);
      else if (r < 10) begin
        if (!m_hi) cyc(1, 0, 8'(1 + $urandom % 12), $urandom % 2);
        else cyc(1, 0, 8'h00, $urandom % 2);
      end else cyc(0, 0, 8'h00, ($urandom % 4) != 0);
    end

    summary();
    $finish;
  end

endmodule